// File: doc/BRIEF.md
# Byte-Register Serial Transmitter

This block is the transmit half of an asynchronous serial port, driven by a host through six byte-wide registers. The registers are a status byte, two control bytes, a 16-bit rate divisor split across two bytes, and a data byte. Each character the host writes to the data register is placed in a one-entry holding buffer. It moves into a frame shifter as soon as that shifter is idle, and leaves on the `tx_out` line as a start bit, 5 to 9 data bits, optional parity and one or two stop bits.

Two flags follow the flow of characters. The buffer-empty flag shows that the holding buffer can take another character. The transmit-done flag shows that the line has gone quiet with nothing queued. Each flag drives a level interrupt request through its own enable. The transmit-done flag is cleared when the host acknowledges its interrupt or writes a 1 to that flag's status bit. Status and control bits that belong to receive, clocked mode, clock polarity or multi-drop addressing are stored or read as zero, and have no other effect.

Register addresses: 0 status, 1 control B, 2 control C, 3 divisor low, 4 divisor high, 5 data. A read presents the addressed register on `reg_rdata` one cycle later.

Top module: `serial_tx_port`

## Requirements
- R1: After reset the status register reads 0x20 (only buffer-empty set) and control C reads 0x06. Control B and both divisor bytes read 0x00. `tx_out` is 1 and both interrupt outputs are 0.
- R2: A bit lasts 16 × (D + 1) clocks when status bit 1 (double speed) is 0, and 8 × (D + 1) clocks when it is 1. D is {divisor high, divisor low}.
- R3: The size code {control B bit 2, control C bits 2:1} gives 5, 6, 7 and 8 data bits for codes 0 to 3, and 9 data bits for codes 4 to 7.
- R4: A frame is one 0 start bit followed by the data bits, least significant first. The ninth data bit is taken from control B bit 0 at the moment the character enters the shifter. The line rests at 1.
- R5: Control C bits 5:4 select the parity bit that follows the data: 2 gives even parity, 3 gives odd parity, and 0 or 1 give no parity bit.
- R6: One stop bit (value 1) ends the frame. When control C bit 3 is set, there are two stop bits.
- R7: A data write while the transmitter is enabled clears status bit 5 (buffer-empty). The bit is set again in the cycle after the character moves into the idle shifter, and it is never set while a character waits.
- R8: Status bit 6 (transmit-done) is set when the last stop bit ends and no character is waiting. It stays clear between back-to-back frames. Writing 1 to status bit 6 clears it.
- R9: A pulse on `txc_ack` clears transmit-done.
- R10: `irq_empty` equals (buffer-empty AND control B bit 5), and `irq_done` equals (transmit-done AND control B bit 6), each one cycle later.
- R11: A control B write that changes bit 3 (transmitter enable) from 0 to 1 sets buffer-empty.
- R12: While control B bit 3 is 0, `tx_out` is 1, a frame in progress is dropped, a waiting character is discarded, and data writes have no effect.
- R13: Control C, the divisor bytes, control B bits 7:2 and 0, and status bits 1:0 read back as written. Status bits 7 and 4:2, control B bit 1 and the data register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after the address |
| txc_ack | input | 1 | Acknowledge of the transmit-done interrupt |
| tx_out | output | 1 | Serial output |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Transmit-done interrupt request |

## Verification
The bench uses the default 16-bit divisor. It runs most traffic at the shortest bit, 8 clocks (divisor 0, double speed), which makes a full sweep affordable. The sweep crosses all eight size codes, all four parity codes, both stop settings and alternating ninth bits, and checks each frame bit by bit against a frame computed in the bench. Three more bit lengths (32, 24 and 2056 clocks) exercise both speed multipliers and the high divisor byte.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  localparam int FRAME_MAX = 13;
  localparam int LEN_W     = 4;

  localparam logic [2:0] ADR_STAT = 3'd0;
  localparam logic [2:0] ADR_CTLB = 3'd1;
  localparam logic [2:0] ADR_CTLC = 3'd2;
  localparam logic [2:0] ADR_DIVL = 3'd3;
  localparam logic [2:0] ADR_DIVH = 3'd4;
  localparam logic [2:0] ADR_DATA = 3'd5;

  // number of data bits for a 3-bit size code
  function automatic logic [3:0] data_count(input logic [2:0] code);
    if (code < 3'd4) return 4'(code) + 4'd5;
    return 4'd9;
  endfunction

  // frame image, bit 0 goes out first, unused upper bits are idle ones
  function automatic logic [FRAME_MAX-1:0] frame_image(input logic [8:0] d,
                                                       input logic [3:0] n,
                                                       input logic [1:0] pm);
    logic [FRAME_MAX-1:0] f;
    logic                 p;
    f    = '1;
    f[0] = 1'b0;
    p    = 1'b0;
    for (int i = 0; i < 9; i++) begin
      if (i < int'(n)) begin
        f[i+1] = d[i];
        p      = p ^ d[i];
      end
    end
    if (pm == 2'd2)      f[int'(n)+1] = p;
    else if (pm == 2'd3) f[int'(n)+1] = ~p;
    return f;
  endfunction

  function automatic logic [LEN_W-1:0] frame_length(input logic [3:0] n,
                                                    input logic [1:0] pm,
                                                    input logic       two);
    return LEN_W'(4'd1 + n + {3'd0, pm[1]} + (two ? 4'd2 : 4'd1));
  endfunction

endpackage

// File: rtl/serial_tx_baud.sv
module serial_tx_baud #(
  parameter int PER_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] last;

  assign last = period - PER_W'(1);
  assign tick = (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt_q <= '0;
    else if (tick)       cnt_q <= '0;
    else                 cnt_q <= cnt_q + PER_W'(1);
  end
endmodule

// File: rtl/serial_tx_shift.sv
module serial_tx_shift #(
  parameter int FRAME_MAX = 13,
  parameter int LEN_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 load,
  input  logic [FRAME_MAX-1:0] frame_in,
  input  logic [LEN_W-1:0]     len_in,
  input  logic                 tick,
  output logic                 line,
  output logic                 busy,
  output logic                 done
);
  logic [FRAME_MAX-1:0] shreg_q;
  logic [LEN_W-1:0]     left_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      line    <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      shreg_q <= '1;
      left_q  <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        line    <= frame_in[0];
        shreg_q <= {1'b1, frame_in[FRAME_MAX-1:1]};
        left_q  <= len_in - LEN_W'(1);
        busy    <= 1'b1;
      end else if (busy && tick) begin
        if (left_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          line <= 1'b1;
        end else begin
          line    <= shreg_q[0];
          shreg_q <= {1'b1, shreg_q[FRAME_MAX-1:1]};
          left_q  <= left_q - LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/serial_tx_port.sv
module serial_tx_port
  import serial_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       txc_ack,
  output logic       tx_out,
  output logic       irq_empty,
  output logic       irq_done
);
  localparam int HI_W  = DIV_W - 8;
  localparam int PER_W = DIV_W + 5;

  logic [7:0]      ctl_b_q, ctl_c_q, div_lo_q;
  logic [HI_W-1:0] div_hi_q;
  logic            txc_q, dre_q, dbl_q, mpc_q;
  logic [7:0]      hold_q;
  logic            hold_full_q;

  logic                 txen, load_now, data_wr, shift_busy, shift_done, tick;
  logic [PER_W-1:0]     period;
  logic [DIV_W-1:0]     divisor;
  logic [3:0]           nbits;
  logic [FRAME_MAX-1:0] frame;
  logic [LEN_W-1:0]     flen;
  logic                 wr_stat, wr_ctlb;

  assign txen     = ctl_b_q[3];
  assign divisor  = {div_hi_q, div_lo_q};
  assign period   = (PER_W'(divisor) + PER_W'(1)) << (dbl_q ? 3 : 4);
  assign load_now = txen && hold_full_q && !shift_busy;
  assign data_wr  = reg_wr && (reg_addr == ADR_DATA) && txen;
  assign wr_stat  = reg_wr && (reg_addr == ADR_STAT);
  assign wr_ctlb  = reg_wr && (reg_addr == ADR_CTLB);
  assign nbits    = data_count({ctl_b_q[2], ctl_c_q[2:1]});
  assign frame    = frame_image({ctl_b_q[0], hold_q}, nbits, ctl_c_q[5:4]);
  assign flen     = frame_length(nbits, ctl_c_q[5:4], ctl_c_q[3]);

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_b_q     <= 8'h00;
      ctl_c_q     <= 8'h06;
      div_lo_q    <= 8'h00;
      div_hi_q    <= '0;
      txc_q       <= 1'b0;
      dre_q       <= 1'b1;
      dbl_q       <= 1'b0;
      mpc_q       <= 1'b0;
      hold_q      <= 8'h00;
      hold_full_q <= 1'b0;
    end else begin
      if (wr_stat) begin
        dbl_q <= reg_wdata[1];
        mpc_q <= reg_wdata[0];
      end
      if (wr_ctlb)                                 ctl_b_q  <= reg_wdata & 8'hFD;
      if (reg_wr && (reg_addr == ADR_CTLC))        ctl_c_q  <= reg_wdata;
      if (reg_wr && (reg_addr == ADR_DIVL))        div_lo_q <= reg_wdata;
      if (reg_wr && (reg_addr == ADR_DIVH))        div_hi_q <= reg_wdata[HI_W-1:0];

      // transmit-done: set wins over clear
      if (shift_done && !hold_full_q)              txc_q <= 1'b1;
      else if (txc_ack || (wr_stat && reg_wdata[6])) txc_q <= 1'b0;

      // holding buffer and buffer-empty flag
      if (data_wr) begin
        hold_q      <= reg_wdata;
        hold_full_q <= 1'b1;
        dre_q       <= 1'b0;
      end else if (load_now) begin
        hold_full_q <= 1'b0;
        dre_q       <= 1'b1;
      end else if (!txen) begin
        hold_full_q <= 1'b0;
      end
      if (wr_ctlb && reg_wdata[3] && !txen)        dre_q <= 1'b1;
    end
  end

  // registered read port and interrupt requests
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= 8'h00;
      irq_empty <= 1'b0;
      irq_done  <= 1'b0;
    end else begin
      irq_empty <= dre_q && ctl_b_q[5];
      irq_done  <= txc_q && ctl_b_q[6];
      unique case (reg_addr)
        ADR_STAT: reg_rdata <= {1'b0, txc_q, dre_q, 3'b000, dbl_q, mpc_q};
        ADR_CTLB: reg_rdata <= ctl_b_q;
        ADR_CTLC: reg_rdata <= ctl_c_q;
        ADR_DIVL: reg_rdata <= div_lo_q;
        ADR_DIVH: reg_rdata <= 8'(div_hi_q);
        default:  reg_rdata <= 8'h00;
      endcase
    end
  end

  serial_tx_baud #(.PER_W(PER_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .restart (load_now),
    .period  (period),
    .tick    (tick)
  );

  serial_tx_shift #(.FRAME_MAX(FRAME_MAX), .LEN_W(LEN_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .enable   (txen),
    .load     (load_now),
    .frame_in (frame),
    .len_in   (flen),
    .tick     (tick),
    .line     (tx_out),
    .busy     (shift_busy),
    .done     (shift_done)
  );
endmodule

// File: rtl/serial_tx_chk.sv
module serial_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       txen,
  input logic       dre_ie,
  input logic       done_ie,
  input logic       dre,
  input logic       txc,
  input logic       hold_full,
  input logic       load,
  input logic       done,
  input logic       ack,
  input logic       wr,
  input logic [2:0] addr,
  input logic       tx,
  input logic       irq_e,
  input logic       irq_d
);
  assert_start_low_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> !tx);
  assert_idle_high_R12: assert property (@(posedge clk) disable iff (rst)
    !txen |=> tx);
  assert_write_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 3'd5 && !txen && !hold_full) |=> !hold_full);
  assert_empty_excl_R7: assert property (@(posedge clk) disable iff (rst)
    hold_full |-> !dre);
  assert_done_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(txc) |-> $past(done));
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (ack && !done) |=> !txc);
  assert_irq_empty_R10: assert property (@(posedge clk) disable iff (rst)
    (dre && dre_ie) |=> irq_e);
  assert_irq_empty_off_R10: assert property (@(posedge clk) disable iff (rst)
    !(dre && dre_ie) |=> !irq_e);
  assert_irq_done_R10: assert property (@(posedge clk) disable iff (rst)
    (txc && done_ie) |=> irq_d);
endmodule

bind serial_tx_port serial_tx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .txen      (ctl_b_q[3]),
  .dre_ie    (ctl_b_q[5]),
  .done_ie   (ctl_b_q[6]),
  .dre       (dre_q),
  .txc       (txc_q),
  .hold_full (hold_full_q),
  .load      (load_now),
  .done      (shift_done),
  .ack       (txc_ack),
  .wr        (reg_wr),
  .addr      (reg_addr),
  .tx        (tx_out),
  .irq_e     (irq_empty),
  .irq_d     (irq_done)
);

// File: tb/tb_serial_tx_port.sv
module tb_serial_tx_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = 3'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       txc_ack = 1'b0;
  logic       tx_out, irq_empty, irq_done;

  int vecs  = 0;
  int fails = 0;

  always #2 clk = ~clk;

  serial_tx_port dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txc_ack(txc_ack),
    .tx_out(tx_out), .irq_empty(irq_empty), .irq_done(irq_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_start();
    for (int k = 0; k < 200 && tx_out; k++) @(negedge clk);
  endtask

  task automatic measure_start(input int exp, input string tag);
    int n;
    wait_start();
    n = 0;
    while (!tx_out && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp, tag, n, exp);
  endtask

  // one frame at an 8-clock bit, compared bit by bit
  task automatic run_frame(input logic [2:0] code, input logic [1:0] pm,
                           input logic two, input logic [8:0] d, input int idx);
    int nb, len, par;
    logic [12:0] expv, got;
    logic [7:0]  v;
    nb   = (code < 3'd4) ? int'(code) + 5 : 9;
    expv = '1;
    expv[0] = 1'b0;
    par  = 0;
    for (int i = 0; i < nb; i++) begin
      expv[i+1] = d[i];
      par = par ^ int'(d[i]);
    end
    len = 1 + nb;
    if (pm == 2'd2) begin expv[len] = par[0];  len++; end
    if (pm == 2'd3) begin expv[len] = ~par[0]; len++; end
    len = len + (two ? 2 : 1);
    wr(3'd2, {2'b00, pm, two, code[1:0], 1'b0});
    wr(3'd1, 8'h48 | {5'd0, code[2], 1'b0, d[8]});
    wr(3'd5, d[7:0]);
    wait_start();
    got = '1;
    idle(4);
    got[0] = tx_out;
    for (int i = 1; i < len; i++) begin
      idle(8);
      got[i] = tx_out;
    end
    chk(got == expv, $sformatf("R3 R4 R5 frame %0d code %0d parity %0d", idx, code, pm),
        int'(got), int'(expv));
    chk(irq_done == 1'b0, "R6 done not before last stop", int'(irq_done), 0);
    idle(7);
    chk(irq_done == 1'b1, "R6 R8 R10 done after last stop", int'(irq_done), 1);
    if (idx % 2 == 1) begin
      @(negedge clk); txc_ack = 1'b1;
      @(negedge clk); txc_ack = 1'b0;
      idle(2);
      chk(irq_done == 1'b0, "R9 ack clears done", int'(irq_done), 0);
    end else begin
      wr(3'd0, 8'h42);
      rd(3'd0, v);
      chk(v[6] == 1'b0, "R8 write-one clears done", int'(v), 8'h22);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int idx;
    idle(4);
    rst = 1'b0;
    // R1 reset state
    chk(tx_out == 1'b1, "R1 line idle", int'(tx_out), 1);
    chk(irq_empty == 1'b0 && irq_done == 1'b0, "R1 irqs low", int'({irq_empty, irq_done}), 0);
    rd(3'd0, v); chk(v == 8'h20, "R1 status", int'(v), 8'h20);
    rd(3'd2, v); chk(v == 8'h06, "R1 control C", int'(v), 8'h06);
    rd(3'd1, v); chk(v == 8'h00, "R1 control B", int'(v), 0);
    rd(3'd3, v); chk(v == 8'h00, "R1 divisor low", int'(v), 0);

    // R13 readback
    wr(3'd1, 8'h37); rd(3'd1, v); chk(v == 8'h35, "R13 control B", int'(v), 8'h35);
    wr(3'd2, 8'hC9); rd(3'd2, v); chk(v == 8'hC9, "R13 control C", int'(v), 8'hC9);
    wr(3'd0, 8'hFF); rd(3'd0, v); chk(v == 8'h23, "R13 status", int'(v), 8'h23);
    wr(3'd3, 8'hA7); rd(3'd3, v); chk(v == 8'hA7, "R13 divisor low", int'(v), 8'hA7);
    wr(3'd4, 8'h3C); rd(3'd4, v); chk(v == 8'h3C, "R13 divisor high", int'(v), 8'h3C);
    rd(3'd5, v); chk(v == 8'h00, "R13 data reads zero", int'(v), 0);
    chk(irq_empty == 1'b1, "R10 empty irq with enable", int'(irq_empty), 1);

    // R12 disabled transmitter ignores data
    wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd0, 8'h02); wr(3'd2, 8'h06);
    wr(3'd5, 8'h55);
    rd(3'd0, v); chk(v[5] == 1'b1, "R12 data write ignored", int'(v), 8'h22);
    chk(tx_out == 1'b1, "R12 line high while off", int'(tx_out), 1);
    wr(3'd1, 8'h08);
    wait_start();
    chk(tx_out == 1'b1, "R12 no frame from ignored write", int'(tx_out), 1);

    // R2 bit length
    wr(3'd0, 8'h00); wr(3'd3, 8'h01);
    wr(3'd5, 8'h01); measure_start(32, "R2 16x divisor 1"); idle(12 * 32);
    wr(3'd0, 8'h02); wr(3'd3, 8'h02);
    wr(3'd5, 8'h01); measure_start(24, "R2 8x divisor 2"); idle(12 * 24);
    wr(3'd3, 8'h00); wr(3'd4, 8'h01);
    wr(3'd5, 8'h01); measure_start(2056, "R2 high byte"); idle(11 * 2056);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h42);

    // R7 R8 back to back
    wr(3'd5, 8'h11); wr(3'd5, 8'h22);
    rd(3'd0, v); chk(v[5] == 1'b0, "R7 empty clear while waiting", int'(v), 8'h02);
    idle(95);
    rd(3'd0, v); chk(v[5] == 1'b1 && v[6] == 1'b0, "R7 R8 second in shifter", int'(v), 8'h22);
    idle(100);
    rd(3'd0, v); chk(v[6] == 1'b1, "R8 done after last frame", int'(v), 8'h62);
    wr(3'd0, 8'h42);

    // R10 empty interrupt follows the flag
    wr(3'd1, 8'h28); idle(2);
    chk(irq_empty == 1'b1, "R10 empty irq set", int'(irq_empty), 1);
    wr(3'd5, 8'h33); wr(3'd5, 8'h44); idle(2);
    chk(irq_empty == 1'b0, "R10 empty irq drops", int'(irq_empty), 0);
    idle(200);
    chk(irq_empty == 1'b1, "R10 empty irq returns", int'(irq_empty), 1);
    wr(3'd0, 8'h42);

    // R11 enable edge sets empty; R12 abort drops waiting char
    wr(3'd1, 8'h08);
    wr(3'd5, 8'h66); wr(3'd5, 8'h77);
    wr(3'd1, 8'h00);
    rd(3'd0, v); chk(v[5] == 1'b0, "R11 empty still clear when off", int'(v), 8'h02);
    chk(tx_out == 1'b1, "R12 frame dropped on disable", int'(tx_out), 1);
    wr(3'd1, 8'h08);
    rd(3'd0, v); chk(v[5] == 1'b1, "R11 enable edge sets empty", int'(v), 8'h22);
    wait_start();
    chk(tx_out == 1'b1, "R12 waiting char discarded", int'(tx_out), 1);

    // sweep of frame formats
    idx = 0;
    for (int c = 0; c < 8; c++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 2; k++) begin
            run_frame(3'(c), 2'(p), 1'(s), (k == 0) ? 9'h1A5 : 9'h03C, idx);
            idx++;
          end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule